// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Persistent Address Pointer

This block is the bus-side logic of a small serial memory that sits on a two-wire bus made of an open-drain clock line and an open-drain data line. It watches both lines on the system clock, finds start and stop conditions, compares the incoming device byte against a fixed type code and three strap pins, and acknowledges when they match. Behind it is a 256-byte register array, reached through a plain synchronous port: an address, a write strobe with write data, and read data that the array returns for the presented address.

The core of the block is one address pointer that lasts from one transaction to the next. A read that carries no word address returns the byte at the pointer, and the pointer steps on by one after each byte is sent. A write loads the pointer from a word address byte and then stores data bytes. Each stored byte moves the pointer within an aligned 8-byte page, so the upper five bits of the pointer do not change. The data line is only pulled low for acknowledge bits and for zero bits of read data. At all other times it is released.

The controller has these states. IDLE waits for a start. DEV shifts in the device byte. DEV_ACK acknowledges it. WORD shifts in the word address. WORD_ACK acknowledges it. WDATA shifts in a data byte. WDATA_ACK acknowledges it. RDATA shifts out a byte. RD_ACK samples the master's acknowledge. IGNORE stays silent until the next start or stop. Transitions: a start in any state goes to DEV, and a stop in any state goes to IDLE. DEV goes to DEV_ACK on a match and to IGNORE on a mismatch. DEV_ACK goes to RDATA when the R/W bit is 1 and to WORD when it is 0. WORD goes to WORD_ACK. WORD_ACK goes to WDATA. WDATA goes to WDATA_ACK. WDATA_ACK goes back to WDATA. RDATA goes to RD_ACK. RD_ACK goes back to RDATA when the master acknowledges and to IGNORE when it does not.

Top module: `serial_rom_slave`

## Requirements
- R1: A start (data falling while clock is high) restarts address reception from any state, including straight after a word address with no stop. A stop (data rising while clock is high) returns the slave to idle with the data line released.
- R2: A device byte made of bits 1010, then the three select pins, then the R/W bit (MSB first) is acknowledged. The slave pulls data low during the 9th clock.
- R3: A device byte that does not match gets no acknowledge. The slave then drives nothing, writes nothing and leaves the pointer alone until the next start.
- R4: A read (R/W = 1) with no word address returns the byte at the current pointer, MSB first, one bit per clock. A 0 bit is shown by pulling data low.
- R5: During a read, the pointer increases by one on the clock falling edge that ends the 8th data bit. It rolls over from 255 to 0.
- R6: If the master acknowledges a read byte, the next byte follows from the advanced pointer. If it does not acknowledge, the slave stays silent until a stop or start.
- R7: In a write (R/W = 0), the byte after the device byte loads the pointer and is acknowledged.
- R8: Each data byte of a write is acknowledged and stored at the pointer with exactly one write strobe.
- R9: After each stored byte, only the low 3 bits of the pointer advance, wrapping inside the 8-byte page. The upper 5 bits do not change.
- R10: The pointer is 0 after reset and keeps its value between transactions. The data line is released after reset.
- R11: The slave changes its data-line drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| sel_i | input | 3 | Device select straps matched against the device byte |
| mem_addr | output | 8 | Array address, always equal to the pointer |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | One-cycle write strobe |
| mem_rdata | input | 8 | Array contents at mem_addr |

## Verification
Bus edges reach the controller through two synchroniser flops and one edge register. As a result, sda_oe settles no later than three system clocks after the bus clock edge that causes the change, and the write strobe appears in the third clock after the falling edge that ends a data byte. The bench holds each bus clock phase for 16 system clocks. A behavioural model opens a per-clock comparison window for sda_oe starting 8 clocks into each high phase and closes it before the next fall, so each comparison is made only after the result is due. Write strobes are compared against a queue of expected address and data pairs on every clock. Read bytes, acknowledges and final array contents are compared against the bench's own pointer and memory model.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_IGNORE
    } srs_state_t;

    localparam logic [3:0] SRS_DEV_TYPE = 4'b1010;

endpackage

// File: rtl/srs_line_sync.sv
module srs_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o,
    output logic q_prev_o
);

    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe     <= {STAGES{RST_VAL}};
            q_prev_o <= RST_VAL;
        end else begin
            pipe     <= {pipe[STAGES-2:0], d_i};
            q_prev_o <= pipe[STAGES-1];
        end
    end

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/srs_cond_detect.sv
module srs_cond_detect (
    input  logic scl,
    input  logic scl_prev,
    input  logic sda,
    input  logic sda_prev,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);

    logic scl_held;

    always_comb begin
        scl_held   = scl && scl_prev;
        start_o    = scl_held && sda_prev && !sda;
        stop_o     = scl_held && !sda_prev && sda;
        scl_rise_o = scl && !scl_prev;
        scl_fall_o = !scl && scl_prev;
    end

endmodule

// File: rtl/srs_word_ptr.sv
module srs_word_ptr #(
    parameter int AW        = 8,
    parameter int PAGE_BITS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          inc_read_i,
    input  logic          inc_write_i,
    output logic [AW-1:0] ptr_o
);

    localparam int HI_BITS = AW - PAGE_BITS;

    logic [HI_BITS-1:0]   hi_q;
    logic [PAGE_BITS-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (load_i) begin
            {hi_q, lo_q} <= load_val_i;
        end else if (inc_read_i) begin
            {hi_q, lo_q} <= {hi_q, lo_q} + AW'(1);
        end else if (inc_write_i) begin
            lo_q <= lo_q + PAGE_BITS'(1);
        end
    end

    assign ptr_o = {hi_q, lo_q};

    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_read_i && !load_i) |=> (ptr_o == AW'($past(ptr_o) + AW'(1)))); // R5

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_write_i && !load_i && !inc_read_i) |=> (ptr_o[AW-1:PAGE_BITS] == $past(ptr_o[AW-1:PAGE_BITS]))); // R9

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i || inc_read_i || inc_write_i) |=> $stable(ptr_o)); // R10

endmodule

// File: rtl/serial_rom_slave.sv
module serial_rom_slave
    import srs_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SEL_W       = 3,
    parameter int PAGE_BITS   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [SEL_W-1:0] sel_i,
    output logic [DW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_we,
    input  logic [DW-1:0]    mem_rdata
);

    localparam int AW    = DW;
    localparam int CNT_W = $clog2(DW + 1);

    logic scl_s, scl_q, sda_s, sda_q;
    logic start_c, stop_c, scl_rise, scl_fall;

    srs_state_t        state, nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DW-1:0]     shreg;
    logic [DW-1:0]     txreg;
    logic              rw_q;
    logic              mack_q;
    logic              rx_st, rx_done, tx_last;
    logic              ptr_load, inc_rd;
    logic [AW-1:0]     ptr;

    srs_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s), .q_prev_o(scl_q)
    );

    srs_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s), .q_prev_o(sda_q)
    );

    srs_cond_detect u_cond (
        .scl(scl_s), .scl_prev(scl_q), .sda(sda_s), .sda_prev(sda_q),
        .start_o(start_c), .stop_o(stop_c),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
    );

    srs_word_ptr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .load_i(ptr_load), .load_val_i(shreg),
        .inc_read_i(inc_rd), .inc_write_i(mem_we),
        .ptr_o(ptr)
    );

    always_comb begin
        rx_st   = (state == ST_DEV) || (state == ST_WORD) || (state == ST_WDATA);
        rx_done = rx_st && scl_fall && (bit_cnt == CNT_W'(DW));
        tx_last = (state == ST_RDATA) && scl_fall && (bit_cnt == CNT_W'(DW - 1));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        if (stop_c) begin
            nxt = ST_IDLE;
        end else if (start_c) begin
            nxt = ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_DEV:       if (rx_done)
                                  nxt = (shreg[DW-1:1] == {SRS_DEV_TYPE, sel_i}) ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:   if (scl_fall) nxt = rw_q ? ST_RDATA : ST_WORD;
                ST_WORD:      if (rx_done)  nxt = ST_WORD_ACK;
                ST_WORD_ACK:  if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (rx_done)  nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (tx_last)  nxt = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall) nxt = mack_q ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    nxt = ST_IGNORE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // bit counter, shifters, captured flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else begin
            if (start_c || stop_c || (nxt != state))
                bit_cnt <= '0;
            else if ((rx_st && scl_rise) || ((state == ST_RDATA) && scl_fall))
                bit_cnt <= bit_cnt + CNT_W'(1);

            if (rx_st && scl_rise)
                shreg <= {shreg[DW-2:0], sda_s};

            if ((state == ST_DEV) && rx_done)
                rw_q <= shreg[0];

            if ((state == ST_RD_ACK) && scl_rise)
                mack_q <= !sda_s;

            if (((state == ST_DEV_ACK) && scl_fall && rw_q) ||
                ((state == ST_RD_ACK) && scl_fall && mack_q))
                txreg <= mem_rdata;
            else if ((state == ST_RDATA) && scl_fall)
                txreg <= {txreg[DW-2:0], 1'b0};
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_WORD_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = !txreg[DW-1];
            default:                               sda_oe = 1'b0;
        endcase
        ptr_load  = (state == ST_WORD) && rx_done;
        mem_we    = (state == ST_WDATA) && rx_done;
        inc_rd    = tx_last;
        mem_addr  = ptr;
        mem_wdata = shreg;
    end

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (state == ST_IDLE)); // R1

    AST_START_TO_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> ((state == ST_DEV) && (bit_cnt == '0))); // R1

    AST_MISMATCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DEV) && rx_done && (shreg[DW-1:DW-4] != SRS_DEV_TYPE)) |=> (state == ST_IGNORE)); // R3

    AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R11

endmodule

// File: tb/serial_rom_slave_test.sv
module serial_rom_slave_test;

    localparam int H      = 16;
    localparam int SETTLE = 8;

    logic       clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       master_sda = 1'b1;
    logic       sda_oe;
    logic [2:0] sel = 3'b101;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_we;
    wire        sda_line = master_sda & ~sda_oe;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mem [256];
    logic [7:0]  ref_mem [256];
    int          ref_ptr = 0;
    logic [15:0] exp_wr [$];
    logic [7:0]  wr_q [$];

    logic  win_en = 1'b0;
    logic  win_exp = 1'b0;
    string win_req = "";

    serial_rom_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .sel_i(sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    // memory array behind the port
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
    end

    // per-clock comparison of the line drive against the model
    always @(negedge clk) begin
        if (win_en) begin
            checks++;
            if (sda_oe !== win_exp) begin
                errors++;
                $display("FAIL %s: sda_oe=%0b expected %0b at %0t", win_req, sda_oe, win_exp, $time);
            end
        end
    end

    // per-clock comparison of write strobes
    always @(negedge clk) begin
        if (rst_n && mem_we === 1'b1) begin
            checks++;
            if (exp_wr.size() == 0) begin
                errors++;
                $display("FAIL R8/R3: unexpected write addr=%0h data=%0h expected none", mem_addr, mem_wdata);
            end else begin
                logic [15:0] e;
                e = exp_wr.pop_front();
                if ({mem_addr, mem_wdata} !== e) begin
                    errors++;
                    $display("FAIL R8: write %0h expected %0h", {mem_addr, mem_wdata}, e);
                end
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): run hung, got timeout expected completion");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic b, input logic exp_oe, input string req, output logic seen);
        master_sda = b;
        wait_clk(H);
        scl = 1'b1;
        wait_clk(SETTLE);
        win_exp = exp_oe;
        win_req = req;
        win_en  = 1'b1;
        seen    = sda_line;
        wait_clk(H - SETTLE);
        win_en = 1'b0;
        scl    = 1'b0;
    endtask

    task automatic bus_start();
        master_sda = 1'b1;
        wait_clk(H);
        scl = 1'b1;
        wait_clk(H);
        master_sda = 1'b0;
        wait_clk(H);
        scl = 1'b0;
        wait_clk(H);
    endtask

    task automatic bus_stop();
        master_sda = 1'b0;
        wait_clk(H);
        scl = 1'b1;
        wait_clk(H);
        master_sda = 1'b1;
        wait_clk(H);
        chk(sda_oe === 1'b0, "R1", "line after stop", sda_oe, 0);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], 1'b0, req, s);
        bit_cycle(1'b1, exp_ack, req, s);
        chk((!s) == exp_ack, req, "acknowledge", !s, exp_ack);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit more, input string req);
        logic [7:0] got;
        logic       s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, ~exp[i], req, s);
            got[i] = s;
        end
        bit_cycle(~more, 1'b0, req, s);
        chk(got === exp, req, "read byte", got, exp);
    endtask

    function automatic logic [7:0] dev_byte(input logic [2:0] s, input logic rw);
        return {4'b1010, s, rw};
    endfunction

    // model: current-address read of n bytes, master acks all but the last
    task automatic do_read(input int n, input string req);
        bus_start();
        send_byte(dev_byte(sel, 1'b1), 1'b1, "R2");
        for (int k = 0; k < n; k++) begin
            recv_byte(ref_mem[ref_ptr], k < n - 1, req);
            ref_ptr = (ref_ptr + 1) % 256;
        end
        bus_stop();
    endtask

    // model: write word address then the bytes in wr_q
    task automatic do_write(input logic [7:0] word, input bit with_stop);
        bus_start();
        send_byte(dev_byte(sel, 1'b0), 1'b1, "R2");
        send_byte(word, 1'b1, "R7");
        ref_ptr = word;
        while (wr_q.size() > 0) begin
            logic [7:0] d;
            d = wr_q.pop_front();
            exp_wr.push_back({8'(ref_ptr), d});
            ref_mem[ref_ptr] = d;
            send_byte(d, 1'b1, "R8");
            ref_ptr = (ref_ptr & 8'hF8) | ((ref_ptr + 1) & 7);
        end
        if (with_stop) bus_stop();
    endtask

    initial begin
        logic s;
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i * 7 + 3);
        wait_clk(5);
        chk(sda_oe === 1'b0, "R10", "sda_oe in reset", sda_oe, 0);
        chk(mem_addr === 8'h00, "R10", "pointer in reset", mem_addr, 0);
        rst_n = 1'b1;
        wait_clk(4);
        chk(mem_we === 1'b0, "R10", "write strobe after reset", mem_we, 0);

        // R4 R10: current read from reset pointer
        do_read(1, "R4");

        // R8 R9: page write crossing the page end
        wr_q = '{8'h11, 8'h22, 8'h33, 8'h44};
        do_write(8'hFD, 1'b1);
        wait_clk(4);
        chk(mem[8'hF8] === 8'h44, "R9", "wrapped page byte", mem[8'hF8], 8'h44);
        chk(mem[8'h00] === 8'h03, "R9", "no spill past page", mem[8'h00], 8'h03);

        // R10: pointer kept across transactions
        do_read(1, "R10");

        // R7: pointer load only, then R5 R6: sequential read through 255 -> 0
        do_write(8'hFE, 1'b1);
        do_read(3, "R5");

        // R3: mismatched select, write attempt ignored
        bus_start();
        send_byte(dev_byte(3'b010, 1'b0), 1'b0, "R3");
        send_byte(8'h10, 1'b0, "R3");
        send_byte(8'h55, 1'b0, "R3");
        bus_stop();
        do_read(1, "R3");

        // R3: mismatched type nibble on a read
        bus_start();
        send_byte({4'b1011, sel, 1'b1}, 1'b0, "R3");
        for (int i = 0; i < 9; i++) bit_cycle(1'b1, 1'b0, "R3", s);
        bus_stop();

        // R1: address aborted by a stop, then a normal read
        bus_start();
        for (int i = 0; i < 4; i++) bit_cycle(i[0], 1'b0, "R1", s);
        bus_stop();
        do_read(1, "R1");

        // R1 R7 R6: word address, repeated start, sequential read
        do_write(8'h40, 1'b0);
        do_read(2, "R6");

        // R6: master acknowledges a byte with no stop after, then stop
        do_read(2, "R6");

        wait_clk(8);
        chk(exp_wr.size() == 0, "R8", "pending writes", exp_wr.size(), 0);
        begin
            int bad = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
            chk(bad == 0, "R8", "array mismatches", bad, 0);
        end
        summary();
        $finish;
    end

endmodule